// File: doc/BRIEF.md
# Flow-Through Burst SRAM

This block is a synthesizable model of a synchronous burst SRAM whose read path has no output register. Each word holds four byte lanes of nine bits: eight data bits and one parity bit. On every rising clock edge the registered control inputs are decoded into one of four kinds of cycle. A deselect cycle powers the device down. A begin cycle loads a new external address. A continue cycle advances a two-bit burst counter. A suspend cycle holds the current address as a wait state. Reads return the word at the registered address within the same clock period, and writes can be limited to any set of byte lanes.

Two strobes load addresses. The processor strobe always begins with a read; a write to that address is made by applying write controls on the following edge while advance is held high. The controller strobe begins a read or a write directly. The three chip enables matter only on edges that load a new address. Burst order can be interleaved or linear. The data bus is driven only while the asynchronous output enable is low and the last active cycle was a read. While the sleep input is high, every other input is ignored and the contents are kept.

Top module: `fts_sram`

## Requirements
- R1: A write is requested when `all_wr_n` is low, in which case all four lanes are written. A write is also requested when `byte_wr_n` is low and at least one bit of `lane_wr_n` is low, in which case only the lanes whose bit is low are written. With `all_wr_n` and `byte_wr_n` both high, the cycle is a read whatever `lane_wr_n` holds.
- R2: Lane i occupies bits [9i+8:9i] of the data word, and bit 9i+8 is its parity bit. A lane enable writes all nine bits of its lane and no bit of any other lane.
- R3: An edge with `proc_strobe_n` low and `en1_n` low loads `addr` and performs a read, ignoring all write inputs on that edge. A write on the next edge with `adv_n` high stores to that same address.
- R4: An edge with `proc_strobe_n` high and `ctrl_strobe_n` low, with `en1_n` low, `en2_n` low and `en3` high, loads `addr` and performs the read or write that R1 selects at that address.
- R5: The block enters a deselected state, in which it stops driving the bus, in two cases: a processor-strobe load with `en1_n` low and either `en2_n` high or `en3` low, or a controller-strobe edge (processor strobe inactive) with `en1_n` high, `en2_n` high or `en3` low. Continue and suspend edges that follow neither write nor drive until a new load succeeds.
- R6: `proc_strobe_n` low is ignored when `en1_n` is high. That edge is then decoded from `ctrl_strobe_n` and `adv_n`.
- R7: A continue edge (both strobes high, `adv_n` low) ignores the chip enables and steps the burst counter by one. With `seq_linear` low, the low two address bits are the loaded low bits XOR the count, giving the order start, start^1, start^2, start^3, and then wrapping back to start. The edge reads or writes per R1 at the new address.
- R8: With `seq_linear` high, the low two address bits are the loaded low bits plus the count, modulo 4. The upper address bits never change during a burst.
- R9: A suspend edge (both strobes and `adv_n` high) keeps the current address and reads or writes per R1 at it.
- R10: While `sleep` is high, the bus is not driven and no edge changes the array, the address or the read/write state. When `sleep` falls, the state from before sleep is still present.
- R11: `dq_drive` is high only when `oe_n` is low, `sleep` is low and the last active cycle was a read. It follows `oe_n` without waiting for a clock edge.
- R12: After a write cycle the bus stays undriven until a later begin, continue or suspend edge performs a read.
- R13: Read data on `dq_out` is the stored word at the registered address and is valid in the same period as the edge that set that address, including a word written on the previous edge.
- R14: After synchronous reset the block is deselected and `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | High freezes the block and releases the bus |
| addr | input | ADDR_W | External word address |
| proc_strobe_n | input | 1 | Processor address strobe, active low, always starts a read |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Primary chip enable, active low |
| en2_n | input | 1 | Second chip enable, active low |
| en3 | input | 1 | Third chip enable, active high |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| byte_wr_n | input | 1 | Qualifies the per-lane enables, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| seq_linear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data, four 9-bit lanes |
| dq_out | output | 36 | Read data at the registered address |
| dq_drive | output | 1 | Tri-state enable for dq_out |

## Verification
The array is first filled with a distinct word at every address, so any wrong address or lane shows up as a data mismatch. Bursts start at non-zero low bits in both orders and run long enough to wrap, which separates XOR stepping from addition and confirms that the upper bits stay fixed. Writes are tried with the global enable, with a single lane including its parity bit, and with lane enables that are not qualified by `byte_wr_n`. Writes are also attempted through a processor-strobe load, while deselected and while asleep; each of these is followed by a read that must return the old word. Drive behaviour is checked after reads, after writes, after each deselect condition and across `oe_n` changes made between clock edges.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        CYC_NONE,
        CYC_DESEL,
        CYC_LOAD,
        CYC_STEP,
        CYC_HOLD
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e          kind;
        logic               wr;
        logic [LANES-1:0]   lanes;
    } cyc_t;

    // low address bits for a given burst count
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] count,
        input logic               linear
    );
        return linear ? (start + count) : (start ^ count);
    endfunction

endpackage

// File: rtl/fts_cycle_decode.sv
module fts_cycle_decode
    import fts_pkg::*;
(
    input  logic             sleep,
    input  logic             active,
    input  logic             proc_strobe_n,
    input  logic             ctrl_strobe_n,
    input  logic             adv_n,
    input  logic             en1_n,
    input  logic             en2_n,
    input  logic             en3,
    input  logic             all_wr_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output cyc_t             cyc
);

    logic [LANES-1:0] req_lanes;
    logic             req_wr;

    always_comb begin
        if (!all_wr_n)       req_lanes = '1;
        else if (!byte_wr_n) req_lanes = ~lane_wr_n;
        else                 req_lanes = '0;
        req_wr = |req_lanes;
    end

    always_comb begin
        cyc.kind  = CYC_NONE;
        cyc.wr    = 1'b0;
        cyc.lanes = '0;
        if (!sleep) begin
            if (!proc_strobe_n && !en1_n) begin
                // processor load: read only, write inputs ignored
                cyc.kind = (en2_n || !en3) ? CYC_DESEL : CYC_LOAD;
            end else if (!ctrl_strobe_n) begin
                if (en1_n || en2_n || !en3) begin
                    cyc.kind = CYC_DESEL;
                end else begin
                    cyc.kind  = CYC_LOAD;
                    cyc.wr    = req_wr;
                    cyc.lanes = req_lanes;
                end
            end else if (active) begin
                cyc.kind  = adv_n ? CYC_HOLD : CYC_STEP;
                cyc.wr    = req_wr;
                cyc.lanes = req_lanes;
            end
        end
    end

endmodule

// File: rtl/fts_burst_addr.sv
module fts_burst_addr
    import fts_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_kind_e         kind,
    input  logic              linear,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] tgt_addr
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] count_q;
    logic [BURST_W-1:0] count_nx;

    always_comb begin
        count_nx = (kind == CYC_STEP) ? count_q + 1'b1 : count_q;
        cur_addr = {base_q[ADDR_W-1 -: HI_W],
                    burst_low(base_q[BURST_W-1:0], count_q, linear)};
        if (kind == CYC_LOAD)
            tgt_addr = ext_addr;
        else
            tgt_addr = {base_q[ADDR_W-1 -: HI_W],
                        burst_low(base_q[BURST_W-1:0], count_nx, linear)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            count_q <= '0;
        end else if (kind == CYC_LOAD) begin
            base_q  <= ext_addr;
            count_q <= '0;
        end else begin
            count_q <= count_nx;
        end
    end

    assert_step_count_R7: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_STEP) |=> (count_q == $past(count_q) + 1'b1));

    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_STEP) |=> (cur_addr[ADDR_W-1 -: HI_W] == $past(cur_addr[ADDR_W-1 -: HI_W])));

    assert_hold_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_HOLD && $stable(linear)) |=> $stable(cur_addr));

endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array
    import fts_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we_lanes,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lanes[g])
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic              en1_n,
    input  logic              en2_n,
    input  logic              en3,
    input  logic              all_wr_n,
    input  logic              byte_wr_n,
    input  logic [3:0]        lane_wr_n,
    input  logic              seq_linear,
    input  logic              oe_n,
    input  logic [35:0]       dq_in,
    output logic [35:0]       dq_out,
    output logic              dq_drive
);

    cyc_t              cyc;
    logic              active_q;
    logic              rd_q;
    logic [LANES-1:0]  we;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] tgt_addr;

    fts_cycle_decode u_decode (
        .sleep         (sleep),
        .active        (active_q),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .en1_n         (en1_n),
        .en2_n         (en2_n),
        .en3           (en3),
        .all_wr_n      (all_wr_n),
        .byte_wr_n     (byte_wr_n),
        .lane_wr_n     (lane_wr_n),
        .cyc           (cyc)
    );

    fts_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .kind     (cyc.kind),
        .linear   (seq_linear),
        .ext_addr (addr),
        .cur_addr (cur_addr),
        .tgt_addr (tgt_addr)
    );

    assign we = cyc.wr ? cyc.lanes : '0;

    fts_lane_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .we_lanes (we),
        .waddr    (tgt_addr),
        .wdata    (dq_in),
        .raddr    (cur_addr),
        .rdata    (dq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            case (cyc.kind)
                CYC_DESEL: begin
                    active_q <= 1'b0;
                    rd_q     <= 1'b0;
                end
                CYC_LOAD, CYC_STEP, CYC_HOLD: begin
                    active_q <= 1'b1;
                    rd_q     <= !cyc.wr;
                end
                default: ;
            endcase
        end
    end

    assign dq_drive = rd_q && !oe_n && !sleep;

    assert_proc_load_reads_R3: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !proc_strobe_n && !en1_n) |-> (we == '0));

    assert_ctrl_deselect_R5: assert property (@(posedge clk) disable iff (rst)
        (!sleep && proc_strobe_n && !ctrl_strobe_n && en1_n) |=> !dq_drive);

    assert_sleep_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (we == '0));

    assert_sleep_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(cur_addr));

    assert_quiet_after_write_R12: assert property (@(posedge clk) disable iff (rst)
        (we != '0) |=> !dq_drive);

endmodule

// File: tb/fts_sram_test.sv
module fts_sram_test;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sleep = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              proc_strobe_n = 1'b1;
    logic              ctrl_strobe_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              en1_n = 1'b0;
    logic              en2_n = 1'b0;
    logic              en3 = 1'b1;
    logic              all_wr_n = 1'b1;
    logic              byte_wr_n = 1'b1;
    logic [3:0]        lane_wr_n = 4'hF;
    logic              seq_linear = 1'b0;
    logic              oe_n = 1'b0;
    logic [35:0]       dq_in = '0;
    logic [35:0]       dq_out;
    logic              dq_drive;

    int total = 0;
    int bad   = 0;
    logic finished = 1'b0;
    logic [35:0] ref_mem [DEPTH];

    fts_sram #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .sleep(sleep), .addr(addr),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .adv_n(adv_n), .en1_n(en1_n), .en2_n(en2_n), .en3(en3),
        .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
        .seq_linear(seq_linear), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [35:0] pat(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {4'h5, b, ~b, b + 8'd3, b ^ 8'h5A};
    endfunction

    task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one clock edge with the given controls; returns 1 time unit after it
    task automatic cyc(input logic ps, input logic cs, input logic av,
                       input logic e1, input logic e2, input logic e3,
                       input logic g, input logic b, input logic [3:0] lw,
                       input logic [7:0] a, input logic [35:0] d);
        proc_strobe_n = ps; ctrl_strobe_n = cs; adv_n = av;
        en1_n = e1; en2_n = e2; en3 = e3;
        all_wr_n = g; byte_wr_n = b; lane_wr_n = lw;
        addr = a; dq_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic load_wr(input logic [7:0] a, input logic [35:0] d);
        cyc(1, 0, 1, 0, 0, 1, 0, 1, 4'hF, a, d);
    endtask

    task automatic load_rd(input logic [7:0] a);
        cyc(1, 0, 1, 0, 0, 1, 1, 1, 4'hF, a, '0);
    endtask

    task automatic step_rd();
        cyc(1, 1, 0, 1, 1, 0, 1, 1, 4'hF, 8'h00, '0);
    endtask

    task automatic hold_rd();
        cyc(1, 1, 1, 0, 0, 1, 1, 1, 4'hF, 8'h00, '0);
    endtask

    task automatic t_reset();
        check("R14 drive after reset", {35'd0, dq_drive}, 36'd0);
    endtask

    task automatic t_prefill();
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = pat(i);
            load_wr(8'(i), pat(i));
        end
        check("R12 no drive after write", {35'd0, dq_drive}, 36'd0);
    endtask

    task automatic t_ctrl_begin();
        load_rd(8'h10);
        check("R4 read drive", {35'd0, dq_drive}, 36'd1);
        check("R4 R13 read data", dq_out, ref_mem[8'h10]);
        load_wr(8'h20, 36'hA_BCDE_F012);
        ref_mem[8'h20] = 36'hA_BCDE_F012;
        load_rd(8'h20);
        check("R4 write then read", dq_out, ref_mem[8'h20]);
    endtask

    task automatic t_lanes();
        logic [35:0] d, m;
        load_rd(8'h40);
        d = ~ref_mem[8'h40];
        m = 36'h0_0003_FE00;
        cyc(1, 1, 1, 0, 0, 1, 1, 0, 4'b1101, 8'h00, d);
        ref_mem[8'h40] = (ref_mem[8'h40] & ~m) | (d & m);
        hold_rd();
        check("R1 single lane write", dq_out, ref_mem[8'h40]);
        check("R2 lane1 with parity", {27'd0, dq_out[17:9]}, {27'd0, d[17:9]});
        cyc(1, 1, 1, 0, 0, 1, 1, 1, 4'b0000, 8'h00, 36'h0);
        check("R1 unqualified lanes read drive", {35'd0, dq_drive}, 36'd1);
        check("R1 unqualified lanes no write", dq_out, ref_mem[8'h40]);
    endtask

    task automatic t_proc_load();
        cyc(0, 1, 1, 0, 0, 1, 0, 1, 4'hF, 8'h50, 36'h1_2345_6789);
        check("R3 proc load reads", {35'd0, dq_drive}, 36'd1);
        check("R3 proc load no write", dq_out, ref_mem[8'h50]);
        cyc(1, 1, 1, 0, 0, 1, 0, 1, 4'hF, 8'h00, 36'h1_2345_6789);
        ref_mem[8'h50] = 36'h1_2345_6789;
        hold_rd();
        check("R3 write on next edge", dq_out, ref_mem[8'h50]);
    endtask

    task automatic t_deselect();
        load_rd(8'h60);
        cyc(1, 0, 1, 1, 0, 1, 1, 1, 4'hF, 8'h60, '0);
        check("R5 ctrl en1 high releases", {35'd0, dq_drive}, 36'd0);
        cyc(1, 1, 0, 0, 0, 1, 0, 1, 4'hF, 8'h00, 36'h0);
        check("R5 inert while deselected", {35'd0, dq_drive}, 36'd0);
        load_rd(8'h61);
        check("R5 no write while deselected", dq_out, ref_mem[8'h61]);
        cyc(0, 1, 1, 0, 1, 1, 1, 1, 4'hF, 8'h62, '0);
        check("R5 proc en2 high deselects", {35'd0, dq_drive}, 36'd0);
        load_rd(8'h62);
        cyc(1, 0, 1, 0, 0, 0, 1, 1, 4'hF, 8'h63, '0);
        check("R5 ctrl en3 low deselects", {35'd0, dq_drive}, 36'd0);
    endtask

    task automatic t_proc_ignored();
        load_rd(8'h70);
        cyc(0, 1, 1, 1, 0, 1, 1, 1, 4'hF, 8'h00, '0);
        check("R6 ignored proc strobe drive", {35'd0, dq_drive}, 36'd1);
        check("R6 ignored proc strobe addr", dq_out, ref_mem[8'h70]);
    endtask

    task automatic t_interleave();
        logic [7:0] seq [4] = '{8'h83, 8'h80, 8'h81, 8'h82};
        seq_linear = 1'b0;
        load_rd(8'h82);
        for (int k = 0; k < 4; k++) begin
            step_rd();
            check("R7 interleaved step", dq_out, ref_mem[seq[k]]);
        end
    endtask

    task automatic t_linear();
        logic [7:0] seq [4] = '{8'h90, 8'h91, 8'h92, 8'h93};
        seq_linear = 1'b1;
        load_rd(8'h93);
        for (int k = 0; k < 4; k++) begin
            step_rd();
            check("R8 linear step", dq_out, ref_mem[seq[k]]);
        end
        seq_linear = 1'b0;
    endtask

    task automatic t_suspend();
        load_rd(8'hA1);
        step_rd();
        check("R9 step before hold", dq_out, ref_mem[8'hA0]);
        hold_rd();
        check("R9 hold keeps address", dq_out, ref_mem[8'hA0]);
        hold_rd();
        check("R9 second hold", dq_out, ref_mem[8'hA0]);
        load_wr(8'hB0, 36'h0_1111_1111);
        cyc(1, 1, 0, 1, 0, 1, 0, 1, 4'hF, 8'h00, 36'h0_2222_2222);
        cyc(1, 1, 0, 1, 0, 1, 0, 1, 4'hF, 8'h00, 36'h0_3333_3333);
        ref_mem[8'hB0] = 36'h0_1111_1111;
        ref_mem[8'hB1] = 36'h0_2222_2222;
        ref_mem[8'hB2] = 36'h0_3333_3333;
        load_rd(8'hB1);
        check("R7 burst write second", dq_out, ref_mem[8'hB1]);
        load_rd(8'hB2);
        check("R7 burst write third", dq_out, ref_mem[8'hB2]);
    endtask

    task automatic t_sleep();
        load_rd(8'hC0);
        sleep = 1'b1;
        #1;
        check("R10 asleep no drive", {35'd0, dq_drive}, 36'd0);
        load_wr(8'hC0, 36'hF_0F0F_0F0F);
        load_wr(8'hC5, 36'hF_0F0F_0F0F);
        sleep = 1'b0;
        #1;
        check("R10 state kept drive", {35'd0, dq_drive}, 36'd1);
        check("R10 contents kept", dq_out, ref_mem[8'hC0]);
        load_rd(8'hC5);
        check("R10 no write while asleep", dq_out, ref_mem[8'hC5]);
    endtask

    task automatic t_oe();
        load_rd(8'hD0);
        oe_n = 1'b1;
        #1;
        check("R11 oe high releases", {35'd0, dq_drive}, 36'd0);
        oe_n = 1'b0;
        #1;
        check("R11 oe low drives", {35'd0, dq_drive}, 36'd1);
    endtask

    task automatic t_after_write();
        load_rd(8'hE0);
        cyc(1, 1, 1, 0, 0, 1, 0, 1, 4'hF, 8'h00, 36'h7_7777_0000);
        ref_mem[8'hE0] = 36'h7_7777_0000;
        check("R12 write releases bus", {35'd0, dq_drive}, 36'd0);
        hold_rd();
        check("R12 read drives again", {35'd0, dq_drive}, 36'd1);
        check("R13 new word next period", dq_out, ref_mem[8'hE0]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_prefill();
        t_ctrl_begin();
        t_lanes();
        t_proc_load();
        t_deselect();
        t_proc_ignored();
        t_interleave();
        t_linear();
        t_suspend();
        t_sleep();
        t_oe();
        t_after_write();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule